// File: doc/BRIEF.md
# Sampled-Data Event Supervisor

This block is a clocked supervisor for a plant described by discrete events. Each plant event has one input line and each prohibitable event has one enable line. The block splits time into sampling periods of `PERIOD` clock cycles. During a period, a sticky capture bit per event records whether that event's input was seen high. At the sampling edge that closes the period, the supervisor moves to a new state. The new state is chosen from the current state and the unordered set of captured events. The order in which events arrived and how many times each one occurred play no part.

The enable outputs are a pure function of the state, so they hold for the whole period. An asserted enable means the controller forces that event to happen before the next sampling edge. The sampling edge counts as the next time step only when no enable is asserted. Transitions are supplied as a parameter list of (from-state, event-set, to-state) rules. Per-state enable masks are supplied as another parameter. The default parameters describe a one-slot buffer:

- event 0 starts a feed into the buffer and is prohibitable;
- event 1 starts a drain out of the buffer and is prohibitable;
- event 2 marks a part arriving in the buffer and is not prohibitable.

Three flags report problems, each for one full period after the edge that found it: a forced event that did not occur, an event set that has no rule, and a prohibitable event that occurred while disabled.

Top module: `sds_supervisor`

## Requirements
- R1: While reset is asserted and right after it is released, the state is `INIT_ST` (0 by default), the enables equal that state's mask (feed only, `ena_o = 2'b01`), and all three error flags are low.
- R2: `ena_o` depends only on the state. The default masks are: state 0 gives `2'b01`, state 1 gives `2'b00`, state 2 gives `2'b10`. `ena_o` changes only in the cycle after a sampling edge.
- R3: `state_o` changes only at a sampling edge.
- R4: At the sampling edge, the next state is taken from the rule that matches the current state and the set of captured events. Default rules, with the set written as {arrive,drain,feed}:
  - from 0, set 001 goes to 1;
  - from 0, set 101 goes to 2;
  - from 1, set 100 goes to 2;
  - from 2, set 010 goes to 0.

  Neither the order of events within the period nor a repeated event changes the result.
- R5: An input that is high only in the cycle whose rising edge is the sampling edge is counted in the following period, not the current one.
- R6: An empty event set keeps the state and does not raise the undefined-transition flag.
- R7: A non-empty set with no matching rule keeps the state and raises `err_undef_o` for the following period. The flag clears after the next edge that finds a defined transition.
- R8: `err_miss_o` is high during the period after an edge when some event that was enabled in the closing period was not captured. Otherwise it is low.
- R9: `err_unena_o` is high during the period after an edge when some prohibitable event was captured while its enable was low. Otherwise it is low.
- R10: `tick_ok_o` is high exactly when every enable output is low.
- R11: `edge_o` is high for one cycle out of every `PERIOD` (4 by default), marking the cycle whose rising edge is the sampling edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ev_i | input | N_EV | One line per plant event; high means the event is occurring |
| ena_o | output | N_CTL | One enable (force) line per prohibitable event, events 0..N_CTL-1 |
| tick_ok_o | output | 1 | High when no event is being forced, so the next edge may count as a time step |
| edge_o | output | 1 | High in the last cycle of each sampling period |
| state_o | output | ST_W | Current supervisor state |
| err_miss_o | output | 1 | A forced event did not occur in the last period |
| err_undef_o | output | 1 | The last period's event set had no rule; the state was held |
| err_unena_o | output | 1 | A prohibitable event occurred while disabled in the last period |

## Verification
Event capture and the state update both fall in the cycle of a sampling edge. An input that is high in that cycle must go to the next period, while the edge consumes the set gathered so far. The bench drives the feed input only in the edge cycle. It then expects the state to hold and the miss flag to rise, and expects the feed to count one period later. A second meeting point lies in the same edge: one captured set can at once take a rule, fail to match any rule, and break an enable. The bench drives a disabled drain in the feeding state and expects the undefined-transition flag and the unenabled-event flag together, with the state held.

// File: rtl/sds_pkg.sv
package sds_pkg;

   // Error flags raised at a sampling edge and held for the following period
   typedef struct packed {
      logic miss;    // a forced event never showed up
      logic undef;   // captured set has no rule from the current state
      logic unena;   // prohibitable event seen while its enable was low
   } sds_flags_t;

endpackage

// File: rtl/sds_capture.sv
// Period counter plus one sticky capture bit per event.
module sds_capture #(
   parameter int N_EV        = 3,
   parameter int PERIOD      = 4,
   parameter bit RISE_DETECT = 1'b0
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [N_EV-1:0] ev_i,
   output logic            edge_o,
   output logic [N_EV-1:0] set_o
);
   localparam int CW = $clog2(PERIOD);
   localparam logic [CW-1:0] LAST = CW'(PERIOD - 1);

   logic [CW-1:0]   cnt_q;
   logic [N_EV-1:0] hit;
   logic [N_EV-1:0] seen_q;

   generate
      if (RISE_DETECT) begin : g_rise
         logic [N_EV-1:0] prev_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) prev_q <= '0;
            else        prev_q <= ev_i;
         end
         assign hit = ev_i & ~prev_q;
      end else begin : g_level
         assign hit = ev_i;
      end
   endgenerate

   assign edge_o = (cnt_q == LAST);
   assign set_o  = seen_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q  <= '0;
         seen_q <= '0;
      end else if (edge_o) begin
         cnt_q  <= '0;
         seen_q <= hit;            // edge-cycle input opens the next period
      end else begin
         cnt_q  <= cnt_q + 1'b1;
         seen_q <= seen_q | hit;
      end
   end
endmodule

// File: rtl/sds_next.sv
// Rule lookup: (current state, captured set) -> next state.
module sds_next #(
   parameter int N_EV   = 3,
   parameter int ST_W   = 2,
   parameter int N_RULE = 4,
   parameter logic [N_RULE*ST_W-1:0] RULE_FROM = '0,
   parameter logic [N_RULE*N_EV-1:0] RULE_SET  = '0,
   parameter logic [N_RULE*ST_W-1:0] RULE_TO   = '0
) (
   input  logic [ST_W-1:0] cur_i,
   input  logic [N_EV-1:0] set_i,
   output logic [ST_W-1:0] nxt_o,
   output logic            undef_o
);
   logic found;

   always_comb begin
      found = 1'b0;
      nxt_o = cur_i;
      for (int r = 0; r < N_RULE; r++) begin
         if (!found && cur_i == RULE_FROM[r*ST_W +: ST_W]
                    && set_i == RULE_SET[r*N_EV +: N_EV]) begin
            found = 1'b1;
            nxt_o = RULE_TO[r*ST_W +: ST_W];
         end
      end
      undef_o = (set_i != '0) && !found;
   end
endmodule

// File: rtl/sds_outmap.sv
// Moore output map: state -> enable mask.
module sds_outmap #(
   parameter int N_CTL = 2,
   parameter int N_ST  = 3,
   parameter int ST_W  = 2,
   parameter logic [N_ST*N_CTL-1:0] ENA_MAP = '0
) (
   input  logic [ST_W-1:0]  st_i,
   output logic [N_CTL-1:0] ena_o
);
   always_comb begin
      ena_o = '0;
      for (int s = 0; s < N_ST; s++) begin
         if (st_i == ST_W'(s)) ena_o = ENA_MAP[s*N_CTL +: N_CTL];
      end
   end
endmodule

// File: rtl/sds_supervisor.sv
module sds_supervisor #(
   parameter int N_EV        = 3,
   parameter int N_CTL       = 2,
   parameter int N_ST        = 3,
   parameter int ST_W        = 2,
   parameter int N_RULE      = 4,
   parameter int PERIOD      = 4,
   parameter bit RISE_DETECT = 1'b0,
   parameter logic [ST_W-1:0] INIT_ST = '0,
   parameter logic [N_RULE*ST_W-1:0] RULE_FROM = {2'd2, 2'd1, 2'd0, 2'd0},
   parameter logic [N_RULE*N_EV-1:0] RULE_SET  = {3'b010, 3'b100, 3'b101, 3'b001},
   parameter logic [N_RULE*ST_W-1:0] RULE_TO   = {2'd0, 2'd2, 2'd2, 2'd1},
   parameter logic [N_ST*N_CTL-1:0]  ENA_MAP   = {2'b10, 2'b00, 2'b01}
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [N_EV-1:0]  ev_i,
   output logic [N_CTL-1:0] ena_o,
   output logic             tick_ok_o,
   output logic             edge_o,
   output logic [ST_W-1:0]  state_o,
   output logic             err_miss_o,
   output logic             err_undef_o,
   output logic             err_unena_o
);
   import sds_pkg::*;

   initial begin
      if (N_CTL < 1 || N_CTL > N_EV) $fatal(1, "N_CTL must lie in 1..N_EV");
      if (PERIOD < 2)                $fatal(1, "PERIOD must be at least 2");
      if ((1 << ST_W) < N_ST)        $fatal(1, "ST_W too narrow for N_ST");
      if (int'(INIT_ST) >= N_ST)     $fatal(1, "INIT_ST out of range");
   end

   logic [N_EV-1:0] set;
   logic [ST_W-1:0] st_q, st_nxt;
   logic            undef;
   sds_flags_t      flg_q, flg_d;

   sds_capture #(.N_EV(N_EV), .PERIOD(PERIOD), .RISE_DETECT(RISE_DETECT)) u_cap (
      .clk(clk), .rst_n(rst_n), .ev_i(ev_i), .edge_o(edge_o), .set_o(set)
   );

   sds_next #(.N_EV(N_EV), .ST_W(ST_W), .N_RULE(N_RULE),
              .RULE_FROM(RULE_FROM), .RULE_SET(RULE_SET), .RULE_TO(RULE_TO)) u_nxt (
      .cur_i(st_q), .set_i(set), .nxt_o(st_nxt), .undef_o(undef)
   );

   sds_outmap #(.N_CTL(N_CTL), .N_ST(N_ST), .ST_W(ST_W), .ENA_MAP(ENA_MAP)) u_out (
      .st_i(st_q), .ena_o(ena_o)
   );

   always_comb begin
      flg_d.miss  = |(ena_o & ~set[N_CTL-1:0]);
      flg_d.undef = undef;
      flg_d.unena = |(~ena_o & set[N_CTL-1:0]);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q  <= INIT_ST;
         flg_q <= '0;
      end else if (edge_o) begin
         st_q  <= st_nxt;
         flg_q <= flg_d;
      end
   end

   assign state_o     = st_q;
   assign tick_ok_o   = ~|ena_o;
   assign err_miss_o  = flg_q.miss;
   assign err_undef_o = flg_q.undef;
   assign err_unena_o = flg_q.unena;
endmodule

// File: rtl/sds_checker.sv
module sds_checker #(
   parameter int N_CTL = 2,
   parameter int ST_W  = 2
) (
   input logic             clk,
   input logic             rst_n,
   input logic             edge_o,
   input logic [ST_W-1:0]  state_o,
   input logic [N_CTL-1:0] ena_o,
   input logic             tick_ok_o,
   input logic             err_miss_o,
   input logic             err_undef_o,
   input logic             err_unena_o
);
   // R3: state moves only at a sampling edge
   a_r3_state_only_at_edge: assert property (@(posedge clk) disable iff (!rst_n)
      !edge_o |=> $stable(state_o));

   // R2: enables held through the period
   a_r2_ena_held: assert property (@(posedge clk) disable iff (!rst_n)
      !edge_o |=> $stable(ena_o));

   // R8: error flags held through the period
   a_r8_flags_held: assert property (@(posedge clk) disable iff (!rst_n)
      !edge_o |=> $stable({err_miss_o, err_undef_o, err_unena_o}));

   // R11: edge is a single-cycle marker
   a_r11_edge_single: assert property (@(posedge clk) disable iff (!rst_n)
      edge_o |=> !edge_o);

   // R7: an undefined set leaves the state where it was
   a_r7_undef_holds: assert property (@(posedge clk) disable iff (!rst_n)
      edge_o |=> (!err_undef_o || $stable(state_o)));

   // R10: time step becomes allowed only right after an edge
   a_r10_tick_rise_after_edge: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(tick_ok_o) |-> $past(edge_o));
endmodule

bind sds_supervisor sds_checker #(.N_CTL(N_CTL), .ST_W(ST_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .edge_o(edge_o), .state_o(state_o), .ena_o(ena_o),
   .tick_ok_o(tick_ok_o), .err_miss_o(err_miss_o), .err_undef_o(err_undef_o),
   .err_unena_o(err_unena_o)
);

// File: tb/sim_sds_supervisor.sv
`timescale 1ns/1ps
module sim_sds_supervisor;
   // event bits: 0 feed, 1 drain, 2 arrive
   localparam logic [2:0] FEED = 3'b001, DRAIN = 3'b010, ARRIVE = 3'b100, NONE = 3'b000;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [2:0] ev = '0;
   logic [1:0] ena, st;
   logic       tick_ok, edg, e_miss, e_undef, e_unena;
   int         checks = 0, errors = 0;
   bit         done = 1'b0;

   always #2 clk = ~clk;

   sds_supervisor u0 (
      .clk(clk), .rst_n(rst_n), .ev_i(ev), .ena_o(ena), .tick_ok_o(tick_ok),
      .edge_o(edg), .state_o(st), .err_miss_o(e_miss), .err_undef_o(e_undef),
      .err_unena_o(e_unena)
   );

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   // full observable picture after an edge
   task automatic chk_all(input string req, input int s, input int en, input int m,
                          input int u, input int x);
      chk({req, " state"}, st, s);
      chk({req, " ena"}, ena, en);
      chk({req, " tick_ok R10"}, tick_ok, (en == 0));
      chk({req, " miss"}, e_miss, m);
      chk({req, " undef"}, e_undef, u);
      chk({req, " unena"}, e_unena, x);
   endtask

   // Starts at the falling edge of cycle 0 of a period, ends at the falling edge
   // of cycle 0 of the next period (just after the sampling edge).
   task automatic period(input logic [2:0] m0, m1, m2, m3);
      logic [2:0] m [4];
      m[0] = m0; m[1] = m1; m[2] = m2; m[3] = m3;
      for (int k = 0; k < 4; k++) begin
         ev = m[k];
         @(negedge clk);
      end
      ev = NONE;
   endtask

   task automatic t_reset;
      @(negedge clk);
      chk_all("R1 in reset", 0, 1, 0, 0, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk_all("R1 after release", 0, 1, 0, 0, 0);
   endtask

   task automatic t_edge_spacing;
      int n;
      while (!edg) @(negedge clk);
      n = 0;
      do begin @(negedge clk); n++; end while (!edg);
      chk("R11 edge spacing", n, 4);
      @(negedge clk);
      chk("R11 edge single", edg, 0);
   endtask

   task automatic t_feed_then_idle;
      period(NONE, FEED, NONE, NONE);
      chk_all("R4 feed 0->1", 1, 0, 0, 0, 0);
      period(NONE, NONE, NONE, NONE);
      chk_all("R6 empty holds", 1, 0, 0, 0, 0);
      period(NONE, NONE, ARRIVE, NONE);
      chk_all("R4 arrive 1->2", 2, 2, 0, 0, 0);
   endtask

   task automatic t_miss_and_repeat;
      period(NONE, NONE, NONE, NONE);
      chk_all("R8 drain missed", 2, 2, 1, 0, 0);
      period(DRAIN, NONE, DRAIN, NONE);
      chk_all("R4 repeated drain 2->0", 0, 1, 0, 0, 0);
   endtask

   task automatic t_order;
      period(ARRIVE, NONE, FEED, NONE);
      chk_all("R4 arrive-then-feed 0->2", 2, 2, 0, 0, 0);
      period(NONE, DRAIN, NONE, NONE);
      chk_all("R4 drain 2->0", 0, 1, 0, 0, 0);
      period(FEED, NONE, ARRIVE, NONE);
      chk_all("R4 feed-then-arrive 0->2", 2, 2, 0, 0, 0);
      period(NONE, NONE, DRAIN, NONE);
      chk_all("R4 drain again 2->0", 0, 1, 0, 0, 0);
   endtask

   task automatic t_edge_cycle_input;
      period(NONE, NONE, NONE, FEED);
      chk_all("R5 edge-cycle feed deferred", 0, 1, 1, 0, 0);
      period(NONE, NONE, NONE, NONE);
      chk_all("R5 deferred feed counted", 1, 0, 0, 0, 0);
   endtask

   task automatic t_undefined;
      period(NONE, DRAIN, NONE, NONE);
      chk_all("R7 R9 disabled drain in state 1", 1, 0, 0, 1, 1);
      period(ARRIVE, NONE, NONE, NONE);
      chk_all("R7 flag clears on defined step", 2, 2, 0, 0, 0);
   endtask

   initial begin
      t_reset();
      t_edge_spacing();
      t_feed_then_idle();
      t_miss_and_repeat();
      t_order();
      t_edge_cycle_input();
      t_undefined();
      if (!done) begin
         done = 1'b1;
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (5000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         checks++; errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule